// File: doc/BRIEF.md
# Serial Text Command to Register Bus Bridge

This block connects an asynchronous serial line to a single-master register bus. It lets a terminal, or a host script, read and write 16-bit registers by typing short text commands. A write is `W AAAA DDDD ` and a read is `R AAAA `. Each command ends with a space, and address and data are hexadecimal. The block contains everything needed for this: the bit-rate divider, the receiver and transmitter, the command parser, and the bus master with its cycle/strobe/acknowledge handshake.

Once reset is released, the block sends a greeting line. Only after that does it accept commands. A well-formed write becomes one bus write. A read becomes one bus read, and the returned word is sent back as four hex characters followed by a line break. The receiver stays live while a reply is being sent, so a host can stream its next command without waiting for the reply to finish.

Top module: `ucmd_bridge`

## Requirements
- R1: While reset is asserted, `ser_out` is high and `bus_cyc`/`bus_stb` are low.
- R2: After reset, the block transmits the bytes 0x52 0x45 0x41 0x44 0x59 0x0D 0x0A ("READY", CR, LF). Characters received before the last of these has been handed to the transmitter are ignored and cause no bus cycle.
- R3: Each serial character is framed as one low start bit, eight data bits with the LSB first, and two high stop bits. Every bit lasts (PRESCALE+1)*16 clock cycles, and `ser_out` is high when idle. Output bit changes and received-character completions happen only on a 16x oversample tick.
- R4: The sequence 'W', space, four hex digits, space, four hex digits, space produces one bus write with `bus_we`=1. The first four digits form `bus_adr` and the last four form `bus_wdat`, most significant digit first.
- R5: The sequence 'R', space, four hex digits, space produces one bus read with `bus_we`=0 at that address.
- R6: A read reply is the returned word as four hex characters, most significant first, using uppercase 0x41..0x46 for A..F. It is followed by CR (0x0D) and LF (0x0A). A write produces no output.
- R7: `bus_cyc` and `bus_stb` rise together. They stay high, with address, data and direction unchanged, until a cycle in which `bus_ack` is high, and they are low in the following cycle.
- R8: Each accepted command produces exactly one bus cycle, and a cycle's end is followed by at least one idle cycle.
- R9: A character that does not fit the grammar (a non-hex digit, or a non-space where a space is due) discards the command without a bus cycle, and the parser returns to waiting for a command letter.
- R10: A low pulse on `ser_in` that has gone high again by mid-bit is not taken as a start bit, so a character that begins one bit time later is received correctly.
- R11: Lowercase 'w', 'r' and a–f are accepted in the same way as their uppercase forms.
- R12: A command received while a read reply is still being transmitted is decoded and executed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial receive line, idle high |
| ser_out | output | 1 | Serial transmit line, idle high |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_adr | output | 16 | Register address |
| bus_wdat | output | 16 | Write data |
| bus_rdat | input | 16 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
The two functions that overlap in time are the transmitter sending a read reply and the receiver together with the parser taking in the next command. Occasionally the next command's bus cycle coincides with reply characters leaving the serial output. The bench provokes this by sending a read and then, with no gap, a write. It judges the result by checking that the reply text is exact and that the write reaches the bus with the correct address and data. Other checks cover a stretched acknowledge, where the strobe must stay up for exactly the wait cycles plus one, and a start-bit glitch followed closely by a real character.

// File: rtl/ucmd_pkg.sv
package ucmd_pkg;

  localparam int          HEX_DIGITS = 4;
  localparam logic [7:0]  CH_SPACE   = 8'h20;
  localparam logic [7:0]  CH_CR      = 8'h0D;
  localparam logic [7:0]  CH_LF      = 8'h0A;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  typedef enum logic [3:0] {
    PS_BOOT, PS_CMD, PS_SP1, PS_ADR, PS_SP2, PS_DAT, PS_END, PS_WAIT, PS_BUS
  } ps_state_t;

  // returns {valid, nibble}
  function automatic logic [4:0] hex_decode(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)
      return {1'b1, c[3:0]};
    else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
      return {1'b1, c[3:0] + 4'd9};
    else
      return 5'd0;
  endfunction

  function automatic logic [7:0] hex_encode(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'd0, n};
    else           return 8'h37 + {4'd0, n};
  endfunction

  function automatic logic letter_is(input logic [7:0] c, input logic [7:0] upper);
    return (c == upper) || (c == (upper | 8'h20));
  endfunction

endpackage

// File: rtl/ucmd_baud.sv
module ucmd_baud #(
  parameter int PRESCALE = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick16
);
  localparam int             CW  = (PRESCALE < 1) ? 1 : $clog2(PRESCALE + 1);
  localparam logic [CW-1:0]  TOP = CW'(PRESCALE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = (cnt_q == TOP);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick16 <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick16 <= tick_d;
    end
  end
endmodule

// File: rtl/ucmd_rx.sv
module ucmd_rx
  import ucmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       line_in,
  output logic       valid,
  output logic [7:0] data
);
  localparam logic [3:0] MID_TICK  = 4'd6;
  localparam logic [3:0] LAST_TICK = 4'd15;

  logic [1:0] sync_q;
  logic       rxs;
  rx_state_t  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d;
  logic       valid_d;

  assign rxs  = sync_q[1];
  assign data = sh_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (tick16) begin
      case (st_q)
        RX_IDLE: if (!rxs) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: begin
          if (cnt_q == MID_TICK) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rxs ? RX_IDLE : RX_DATA;
          end else cnt_d = cnt_q + 4'd1;
        end
        RX_DATA: begin
          if (cnt_q == LAST_TICK) begin
            cnt_d = '0;
            sh_d  = {rxs, sh_q[7:1]};
            if (idx_q == 3'd7) st_d = RX_STOP;
            else               idx_d = idx_q + 3'd1;
          end else cnt_d = cnt_q + 4'd1;
        end
        RX_STOP: begin
          if (cnt_q == LAST_TICK) begin
            valid_d = rxs;
            st_d    = RX_IDLE;
          end else cnt_d = cnt_q + 4'd1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      valid  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_in};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      valid  <= valid_d;
    end
  end
endmodule

// File: rtl/ucmd_tx.sv
module ucmd_tx
  import ucmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        resp_go,
  input  logic [15:0] resp_val,
  output logic        msg_busy,
  output logic        line_out
);
  // message sequencer
  logic        active_q, active_d;
  logic        banner_q, banner_d;
  logic [2:0]  idx_q, idx_d;
  logic [15:0] val_q, val_d;
  logic        go_q, go_d;
  logic [2:0]  last_idx;
  logic [7:0]  ch;
  logic [3:0]  nib;
  // serializer
  logic        sbusy_q, sbusy_d;
  logic [10:0] sh_q, sh_d;
  logic [3:0]  tcnt_q, tcnt_d;
  logic [3:0]  nbit_q, nbit_d;
  logic        out_q, out_d;

  assign msg_busy = active_q;
  assign line_out = out_q;
  assign last_idx = banner_q ? 3'd6 : 3'd5;
  assign nib      = 4'(val_q >> (4'd12 - {idx_q[1:0], 2'b00}));

  always_comb begin
    if (banner_q) begin
      case (idx_q)
        3'd0:    ch = 8'h52;
        3'd1:    ch = 8'h45;
        3'd2:    ch = 8'h41;
        3'd3:    ch = 8'h44;
        3'd4:    ch = 8'h59;
        3'd5:    ch = CH_CR;
        default: ch = CH_LF;
      endcase
    end else if (idx_q < 3'd4) ch = hex_encode(nib);
    else if (idx_q == 3'd4)    ch = CH_CR;
    else                       ch = CH_LF;
  end

  always_comb begin
    active_d = active_q;
    banner_d = banner_q;
    idx_d    = idx_q;
    val_d    = val_q;
    go_d     = 1'b0;
    if (go_q) begin
      idx_d = idx_q + 3'd1;
      if (idx_q == last_idx) active_d = 1'b0;
    end else if (active_q && !sbusy_q) begin
      go_d = 1'b1;
    end else if (!active_q && resp_go) begin
      active_d = 1'b1;
      banner_d = 1'b0;
      idx_d    = '0;
      val_d    = resp_val;
    end
  end

  always_comb begin
    sbusy_d = sbusy_q;
    sh_d    = sh_q;
    tcnt_d  = tcnt_q;
    nbit_d  = nbit_q;
    out_d   = out_q;
    if (go_q) begin
      sh_d    = {2'b11, ch, 1'b0};
      sbusy_d = 1'b1;
      tcnt_d  = '0;
      nbit_d  = '0;
    end else if (tick16 && sbusy_q) begin
      if (tcnt_q == 4'd0) out_d = sh_q[0];
      tcnt_d = tcnt_q + 4'd1;
      if (tcnt_q == 4'd15) begin
        sh_d   = {1'b1, sh_q[10:1]};
        nbit_d = nbit_q + 4'd1;
        if (nbit_q == 4'd10) sbusy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      banner_q <= 1'b1;
      idx_q    <= '0;
      val_q    <= '0;
      go_q     <= 1'b0;
      sbusy_q  <= 1'b0;
      sh_q     <= '1;
      tcnt_q   <= '0;
      nbit_q   <= '0;
      out_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      banner_q <= banner_d;
      idx_q    <= idx_d;
      val_q    <= val_d;
      go_q     <= go_d;
      sbusy_q  <= sbusy_d;
      sh_q     <= sh_d;
      tcnt_q   <= tcnt_d;
      nbit_q   <= nbit_d;
      out_q    <= out_d;
    end
  end
endmodule

// File: rtl/ucmd_parse.sv
module ucmd_parse
  import ucmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        msg_busy,
  input  logic        bus_ack,
  input  logic [15:0] bus_rdat,
  output logic        bus_cyc,
  output logic        bus_stb,
  output logic        bus_we,
  output logic [15:0] bus_adr,
  output logic [15:0] bus_wdat,
  output logic        resp_go,
  output logic [15:0] resp_val
);
  localparam logic [1:0] LAST_DIGIT = 2'(HEX_DIGITS - 1);

  ps_state_t   st_q, st_d;
  logic        wr_q, wr_d;
  logic [15:0] adr_q, adr_d;
  logic [15:0] dat_q, dat_d;
  logic [1:0]  dcnt_q, dcnt_d;
  logic        go_d;
  logic [15:0] rval_d;
  logic [4:0]  hv;
  logic        is_sp;

  assign hv       = hex_decode(rx_data);
  assign is_sp    = (rx_data == CH_SPACE);
  assign bus_cyc  = (st_q == PS_BUS);
  assign bus_stb  = (st_q == PS_BUS);
  assign bus_we   = wr_q;
  assign bus_adr  = adr_q;
  assign bus_wdat = dat_q;

  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    adr_d  = adr_q;
    dat_d  = dat_q;
    dcnt_d = dcnt_q;
    go_d   = 1'b0;
    rval_d = resp_val;
    case (st_q)
      PS_BOOT: if (!msg_busy) st_d = PS_CMD;
      PS_CMD: if (rx_valid) begin
        if (letter_is(rx_data, 8'h57)) begin
          wr_d = 1'b1;
          st_d = PS_SP1;
        end else if (letter_is(rx_data, 8'h52)) begin
          wr_d = 1'b0;
          st_d = PS_SP1;
        end
      end
      PS_SP1: if (rx_valid) begin
        dcnt_d = '0;
        st_d   = is_sp ? PS_ADR : PS_CMD;
      end
      PS_ADR: if (rx_valid) begin
        if (!hv[4]) st_d = PS_CMD;
        else begin
          adr_d  = {adr_q[11:0], hv[3:0]};
          dcnt_d = dcnt_q + 2'd1;
          if (dcnt_q == LAST_DIGIT) st_d = wr_q ? PS_SP2 : PS_END;
        end
      end
      PS_SP2: if (rx_valid) begin
        dcnt_d = '0;
        st_d   = is_sp ? PS_DAT : PS_CMD;
      end
      PS_DAT: if (rx_valid) begin
        if (!hv[4]) st_d = PS_CMD;
        else begin
          dat_d  = {dat_q[11:0], hv[3:0]};
          dcnt_d = dcnt_q + 2'd1;
          if (dcnt_q == LAST_DIGIT) st_d = PS_END;
        end
      end
      PS_END: if (rx_valid) begin
        if (!is_sp)     st_d = PS_CMD;
        else if (wr_q)  st_d = PS_BUS;
        else            st_d = PS_WAIT;
      end
      PS_WAIT: if (!msg_busy) st_d = PS_BUS;
      PS_BUS: if (bus_ack) begin
        st_d = PS_CMD;
        if (!wr_q) begin
          go_d   = 1'b1;
          rval_d = bus_rdat;
        end
      end
      default: st_d = PS_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_BOOT;
      wr_q     <= 1'b0;
      adr_q    <= '0;
      dat_q    <= '0;
      dcnt_q   <= '0;
      resp_go  <= 1'b0;
      resp_val <= '0;
    end else begin
      st_q     <= st_d;
      wr_q     <= wr_d;
      adr_q    <= adr_d;
      dat_q    <= dat_d;
      dcnt_q   <= dcnt_d;
      resp_go  <= go_d;
      resp_val <= rval_d;
    end
  end
endmodule

// File: rtl/ucmd_bridge.sv
module ucmd_bridge #(
  parameter int PRESCALE = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_in,
  output logic        ser_out,
  output logic        bus_cyc,
  output logic        bus_stb,
  output logic        bus_we,
  output logic [15:0] bus_adr,
  output logic [15:0] bus_wdat,
  input  logic [15:0] bus_rdat,
  input  logic        bus_ack
);
  logic [1:0]  rs_q;
  logic        core_rst_n;
  logic        tick16;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        msg_busy;
  logic        resp_go;
  logic [15:0] resp_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  ucmd_baud #(.PRESCALE(PRESCALE)) baud_i (
    .clk(clk), .rst_n(core_rst_n), .tick16(tick16)
  );

  ucmd_rx rx_i (
    .clk(clk), .rst_n(core_rst_n), .tick16(tick16), .line_in(ser_in),
    .valid(rx_valid), .data(rx_data)
  );

  ucmd_parse parse_i (
    .clk(clk), .rst_n(core_rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .msg_busy(msg_busy), .bus_ack(bus_ack), .bus_rdat(bus_rdat),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat),
    .resp_go(resp_go), .resp_val(resp_val)
  );

  ucmd_tx tx_i (
    .clk(clk), .rst_n(core_rst_n), .tick16(tick16),
    .resp_go(resp_go), .resp_val(resp_val),
    .msg_busy(msg_busy), .line_out(ser_out)
  );
endmodule

// File: rtl/ucmd_bridge_chk.sv
module ucmd_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_out,
  input logic        tick16,
  input logic        rx_valid,
  input logic        bus_cyc,
  input logic        bus_stb,
  input logic        bus_we,
  input logic        bus_ack,
  input logic [15:0] bus_adr,
  input logic [15:0] bus_wdat
);
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=> bus_cyc);

  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack) |=> !bus_cyc);

  assert_request_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=> ($stable(bus_adr) && $stable(bus_wdat) && $stable(bus_we)));

  assert_strobe_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> bus_cyc);

  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cyc) |=> !bus_cyc);

  assert_tx_edge_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $past(tick16));

  assert_rx_done_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick16));
endmodule

bind ucmd_bridge ucmd_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .tick16(tick16),
  .rx_valid(rx_valid), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
  .bus_we(bus_we), .bus_ack(bus_ack), .bus_adr(bus_adr), .bus_wdat(bus_wdat)
);

// File: tb/ucmd_bridge_test.sv
module ucmd_bridge_test;
  localparam int PRE = 1;
  localparam int BIT = (PRE + 1) * 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_in;
  logic        ser_out;
  logic        bus_cyc, bus_stb, bus_we, bus_ack;
  logic [15:0] bus_adr, bus_wdat, bus_rdat;

  always #5 clk = ~clk;

  ucmd_bridge #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  byte unsigned rxq[$];
  logic [15:0] mem [logic [15:0]];
  int ack_delay = 0;
  int ncyc = 0;
  int stb_seen = 0;
  logic        last_we;
  logic [15:0] last_adr, last_dat;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input byte unsigned b);
    @(negedge clk);
    ser_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      repeat (BIT) @(negedge clk);
    end
    ser_in = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic settle();
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic expect_text(input string s, input string req);
    int t;
    string got_h, exp_h;
    t = 0;
    got_h = "";
    exp_h = "";
    while (rxq.size() < s.len() && t < 12 * BIT * (s.len() + 2)) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < s.len(); i++) begin
      exp_h = {exp_h, $sformatf("%02h", s[i])};
      if (rxq.size() > 0) got_h = {got_h, $sformatf("%02h", rxq.pop_front())};
    end
    checks++;
    if (got_h != exp_h) begin
      fails++;
      $display("FAIL %s serial text actual=%s expected=%s", req, got_h, exp_h);
    end
  endtask

  // serial output monitor
  initial begin
    logic [7:0] mb;
    logic s1, s2;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (ser_out === 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        if (ser_out === 1'b0) begin
          for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            mb[i] = ser_out;
          end
          repeat (BIT) @(negedge clk);
          s1 = ser_out;
          repeat (BIT) @(negedge clk);
          s2 = ser_out;
          check(s1 === 1'b1 && s2 === 1'b1, "R3", "stop bits", {30'd0, s1, s2}, 3);
          rxq.push_back(mb);
        end else begin
          check(1'b0, "R3", "start bit width", 1, 0);
        end
      end
    end
  end

  // register slave model
  initial begin
    int wc;
    wc = 0;
    bus_ack  = 1'b0;
    bus_rdat = 16'h0000;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (rst_n === 1'b1 && bus_stb === 1'b1) begin
        stb_seen++;
        if (wc >= ack_delay) begin
          wc       = 0;
          bus_ack  = 1'b1;
          ncyc++;
          last_we  = bus_we;
          last_adr = bus_adr;
          last_dat = bus_wdat;
          if (bus_we) mem[bus_adr] = bus_wdat;
          else bus_rdat = mem.exists(bus_adr) ? mem[bus_adr] : 16'h0000;
        end else begin
          wc++;
        end
      end
    end
  end

  task automatic t_reset();
    ser_in = 1'b1;
    rst_n  = 1'b1;
    #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(ser_out === 1'b1, "R1", "ser_out in reset", int'(ser_out), 1);
    check(bus_cyc === 1'b0 && bus_stb === 1'b0, "R1", "bus idle in reset", int'(bus_cyc), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_banner();
    send_str("W 0005 1111 ");
    expect_text("READY\r\n", "R2");
    check(ncyc == 0, "R2", "no bus cycle during greeting", ncyc, 0);
  endtask

  task automatic t_write();
    int n0;
    n0 = ncyc;
    send_str("W 8002 1234 ");
    settle();
    check(ncyc == n0 + 1, "R8", "one cycle per write", ncyc - n0, 1);
    check(last_we === 1'b1, "R4", "write direction", int'(last_we), 1);
    check(last_adr == 16'h8002, "R4", "write address", last_adr, 16'h8002);
    check(last_dat == 16'h1234, "R4", "write data", last_dat, 16'h1234);
    check(rxq.size() == 0, "R6", "no reply to write", rxq.size(), 0);
  endtask

  task automatic t_read();
    int n0;
    n0 = ncyc;
    send_str("R 8002 ");
    expect_text("1234\r\n", "R6");
    check(ncyc == n0 + 1, "R8", "one cycle per read", ncyc - n0, 1);
    check(last_we === 1'b0 && last_adr == 16'h8002, "R5", "read address", last_adr, 16'h8002);
  endtask

  task automatic t_lower();
    send_str("w 1000 0001 ");
    send_str("r 1000 ");
    expect_text("0001\r\n", "R11");
    send_str("W 8004 9abc ");
    send_str("R 8004 ");
    expect_text("9ABC\r\n", "R6");
    check(mem[16'h8004] == 16'h9ABC, "R11", "lowercase digits", mem[16'h8004], 16'h9ABC);
  endtask

  task automatic t_wait();
    ack_delay = 5;
    stb_seen  = 0;
    send_str("W 8005 DEF0 ");
    settle();
    check(stb_seen == 6, "R7", "strobe held until ack", stb_seen, 6);
    check(last_dat == 16'hDEF0, "R7", "data under wait states", last_dat, 16'hDEF0);
    ack_delay = 0;
  endtask

  task automatic t_abort();
    int n0;
    n0 = ncyc;
    send_str("W 12G4 5678 ");
    settle();
    check(ncyc == n0, "R9", "bad digit discarded", ncyc - n0, 0);
    send_str("W1000 1111 ");
    settle();
    check(ncyc == n0, "R9", "missing space discarded", ncyc - n0, 0);
    send_str("R 1000 ");
    expect_text("0001\r\n", "R9");
  endtask

  task automatic t_glitch();
    int n0;
    n0 = ncyc;
    @(negedge clk);
    ser_in = 1'b0;
    repeat (4 * (PRE + 1)) @(negedge clk);
    ser_in = 1'b1;
    repeat (BIT) @(negedge clk);
    send_str("R 8002 ");
    expect_text("1234\r\n", "R10");
    check(ncyc == n0 + 1, "R10", "glitch made no command", ncyc - n0, 1);
  endtask

  task automatic t_duplex();
    int n0;
    n0 = ncyc;
    send_str("R 8004 ");
    send_str("W 8006 C5C0 ");
    settle();
    expect_text("9ABC\r\n", "R12");
    check(ncyc == n0 + 2, "R12", "both commands ran", ncyc - n0, 2);
    check(last_adr == 16'h8006 && last_we === 1'b1, "R12", "overlapped write address", last_adr, 16'h8006);
    check(last_dat == 16'hC5C0, "R12", "overlapped write data", last_dat, 16'hC5C0);
  endtask

  initial begin
    t_reset();
    t_banner();
    t_write();
    t_read();
    t_lower();
    t_wait();
    t_abort();
    t_glitch();
    t_duplex();
    settle();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule